// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block is a watchdog that counts ticks of a slow timebase. A base counter divides the tick stream. Its overflows drive a postscaler counter, and a 3-bit setting picks the postscaler ratio. Software keeps the watchdog quiet by pulsing a kick strobe, which clears both counters.

Two sources decide whether the watchdog runs. A fixed configuration bit forces it on. When that bit is low, a software-controlled enable bit turns it on or off.

When the full period runs out, the result depends on the sleep indicator:
- While the device runs, the block emits a one-cycle reset pulse and sets a sticky status flag. Software clears the flag.
- While the device sleeps, the block emits a one-cycle wake pulse instead. The device then resumes execution.

Top module: `wdt_postscaled`

## Requirements
- R1: The watchdog is enabled when `cfg_force_en` is 1, whatever `sw_en` holds. When `cfg_force_en` is 0, it is enabled only while `sw_en` is 1. While disabled, no reset or wake pulse is produced.
- R2: Setting `ps_sel` = n selects a postscale ratio of 2^n. A timeout therefore occurs on the 2^BASE_W * 2^n-th counted tick after a clear. n = 0 gives the shortest period and n = 7 the longest.
- R3: Only cycles with `tick` = 1 advance the count. Cycles without a tick leave the time to timeout unchanged.
- R4: A cycle with `kick` = 1 clears the base and postscaler counters. A full period must then elapse before the next timeout, and the kicked cycle itself produces no pulse.
- R5: While the watchdog is disabled, its counters are held at zero. After it is re-enabled, a full period must elapse before a timeout.
- R6: A timeout with `sleep` = 0 drives `wdt_rst` high for exactly one clock cycle. That cycle is the one after the clock edge that sampled the terminal tick.
- R7: `wdt_flag` goes to 1 in the same cycle as a reset pulse and stays at 1 until `flag_clr` is sampled high. If a reset timeout and `flag_clr` occur in the same cycle, the flag ends up set.
- R8: A timeout with `sleep` = 1 drives `wake` high for one cycle, with no reset pulse and no change to `wdt_flag`.
- R9: Entering or leaving sleep does not clear the count. A timeout falls at the same tick count whether or not `sleep` changed during the period.
- R10: After reset, `wdt_rst`, `wake` and `wdt_flag` are 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| cfg_force_en | input | 1 | Fixed configuration enable; forces the watchdog on |
| sw_en | input | 1 | Software enable bit |
| ps_sel | input | 3 | Postscale select, ratio 2^ps_sel |
| kick | input | 1 | Clears both counters |
| sleep | input | 1 | High while the device is in sleep mode |
| flag_clr | input | 1 | Clears the sticky timeout flag |
| wdt_rst | output | 1 | One-cycle reset pulse on a timeout while running |
| wake | output | 1 | One-cycle wake pulse on a timeout while asleep |
| wdt_flag | output | 1 | Sticky flag recording a reset timeout |

## Verification
The bench builds the block with BASE_W = 3. This makes the longest period, at ratio 1:128, only 1024 ticks long. Every one of the eight postscale settings can therefore be run to timeout, and each period length can be checked to the exact tick. The short base counter also lets random runs hit many timeouts. Those runs mix kicks, enable changes, sleep transitions and flag clears near timeout boundaries.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int SEL_W = 3;
    localparam int PS_W  = (1 << SEL_W) - 1;

    typedef struct packed {
        logic rst;
        logic wake;
        logic flag;
    } wdt_out_t;

    function automatic logic [PS_W-1:0] ps_mask(input logic [SEL_W-1:0] sel);
        logic [PS_W:0] one_hot;
        one_hot = (PS_W+1)'(1) << sel;
        return PS_W'(one_hot - (PS_W+1)'(1));
    endfunction

endpackage

// File: rtl/wdt_base_ctr.sv
module wdt_base_ctr #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            wrap     = (st_q.cnt == {W{1'b1}});
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: without a step or clear the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(st_q.cnt));

    // R4/R5: a clear leaves the counter at zero
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdt_post_ctr.sv
module wdt_post_ctr
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } st_t;

    st_t             st_d, st_q;
    logic [PS_W-1:0] mask;

    always_comb begin
        st_d = st_q;
        mask = ps_mask(sel);
        done = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            done = ((st_q.cnt & mask) == mask);
            st_d.cnt = done ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the postscaler restarts after its terminal count
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdt_postscaled.sv
module wdt_postscaled
    import wdt_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_force_en,
    input  logic             sw_en,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic             kick,
    input  logic             sleep,
    input  logic             flag_clr,
    output logic             wdt_rst,
    output logic             wake,
    output logic             wdt_flag
);
    logic     en;
    logic     clr;
    logic     base_wrap;
    logic     timeout;
    wdt_out_t out_d, out_q;

    always_comb begin
        en  = cfg_force_en | sw_en;
        clr = kick | ~en;
    end

    wdt_base_ctr #(.W(BASE_W)) u_base (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (tick),
        .wrap (base_wrap)
    );

    wdt_post_ctr u_post (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (base_wrap),
        .sel  (ps_sel),
        .done (timeout)
    );

    always_comb begin
        out_d      = out_q;
        out_d.rst  = timeout & ~sleep;
        out_d.wake = timeout & sleep;
        if (timeout && !sleep) out_d.flag = 1'b1;
        else if (flag_clr)     out_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign wdt_rst  = out_q.rst;
    assign wake     = out_q.wake;
    assign wdt_flag = out_q.flag;

    // R6: reset pulse lasts one cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    // R8: reset and wake never together
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_rst && wake));

    // R7: a reset pulse always comes with the flag
    a_r7_flag_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> wdt_flag);

    // R1/R5: a disabled cycle yields no pulse
    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_force_en && !sw_en) |=> (!wdt_rst && !wake));

    // R4: a kicked cycle yields no pulse
    a_r4_kick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (!wdt_rst && !wake));

    // R7: the flag is dropped only by a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_flag && !flag_clr) |=> wdt_flag);

endmodule

// File: tb/sim_wdt_postscaled.sv
module sim_wdt_postscaled;
    localparam int CLK_PERIOD = 10;
    localparam int BASE_W     = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 0, cfg_force_en = 0, sw_en = 0, kick = 0, sleep = 0, flag_clr = 0;
    logic [2:0] ps_sel = 0;
    logic       wdt_rst, wake, wdt_flag;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    logic m_flag = 0;
    logic e_rst = 0, e_wake = 0;
    int hits = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_postscaled #(.BASE_W(BASE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_force_en(cfg_force_en),
        .sw_en(sw_en), .ps_sel(ps_sel), .kick(kick), .sleep(sleep),
        .flag_clr(flag_clr), .wdt_rst(wdt_rst), .wake(wake), .wdt_flag(wdt_flag)
    );

    function automatic int period_of(input logic [2:0] s);
        return (1 << BASE_W) * (1 << s);
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic [2:0] ps,
                        input logic k, input logic t, input logic sl,
                        input logic fc, input string tag);
        logic to;
        @(negedge clk);
        cfg_force_en = c; sw_en = s; ps_sel = ps; kick = k;
        tick = t; sleep = sl; flag_clr = fc;
        to = 1'b0;
        if (k || !(c || s)) m_cnt = 0;
        else if (t) begin
            if (m_cnt + 1 == period_of(ps)) begin to = 1'b1; m_cnt = 0; end
            else m_cnt++;
        end
        e_rst  = to & ~sl;
        e_wake = to & sl;
        if (to && !sl) m_flag = 1'b1;
        else if (fc)   m_flag = 1'b0;
        if (to) hits++;
        @(posedge clk);
        #1;
        check({tag, " rst"},  wdt_rst,  e_rst);
        check({tag, " wake"}, wake,     e_wake);
        check({tag, " flag"}, wdt_flag, m_flag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired, got running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int h;
        void'($urandom(32'h5eed_1234));
        #(CLK_PERIOD*2 + 3);
        check("R10 reset rst", wdt_rst, 1'b0);
        check("R10 reset wake", wake, 1'b0);
        check("R10 reset flag", wdt_flag, 1'b0);
        rst_n = 1'b1;

        // R2: every setting, exact period, forced on by configuration (R1)
        for (int s = 0; s < 8; s++) begin
            step(1, 0, 3'(s), 1, 0, 0, 1, "R4 kick");
            h = hits;
            for (int i = 0; i < period_of(3'(s)); i++) step(1, 0, 3'(s), 0, 1, 0, 0, "R2 period");
            check("R2 one timeout per period", hits - h == 1, 1'b1);
        end

        // R1: disabled when both enables low
        for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1, 0, 0, "R1 disabled");
        // R5: re-enabled via software gets a full period
        for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 1, 0, 0, "R5 reenable R1 sw");

        // R3: idle cycles without tick in the middle
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 1, 0, 0, "R3 tick");
        for (int i = 0; i < 20; i++) step(0, 1, 1, 0, 0, 0, 0, "R3 no tick");
        for (int i = 0; i < 12; i++) step(0, 1, 1, 0, 1, 0, 0, "R3 tick");

        // R7: flag clear, then set and clear together
        step(0, 1, 0, 0, 0, 0, 1, "R7 clear");
        for (int i = 0; i < 7; i++) step(0, 1, 0, 0, 1, 0, 0, "R7 run");
        step(0, 1, 0, 0, 1, 0, 1, "R7 set wins");

        // R9/R8: enter sleep mid period, timeout becomes wake
        step(1, 0, 2, 1, 0, 0, 1, "R4 kick");
        for (int i = 0; i < 16; i++) step(1, 0, 2, 0, 1, 0, 0, "R9 awake");
        for (int i = 0; i < 16; i++) step(1, 0, 2, 0, 1, 1, 0, "R8 R9 asleep");

        // R4: kick just before terminal tick
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 1, 0, 0, "R4 run");
        step(1, 0, 0, 1, 1, 0, 0, "R4 kick at terminal");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 1, 0, 0, "R4 full period");

        // random mix; select changes only together with a kick
        begin
            logic [2:0] sel_r = 0;
            logic c_r = 1, s_r = 0, sl_r = 0;
            for (int i = 0; i < 20000; i++) begin
                logic k_r;
                k_r = ($urandom_range(0, 299) == 0);
                if ($urandom_range(0, 499) == 0) begin sel_r = 3'($urandom_range(0, 3)); k_r = 1; end
                if ($urandom_range(0, 799) == 0) c_r = ~c_r;
                if ($urandom_range(0, 399) == 0) s_r = ~s_r;
                if ($urandom_range(0, 149) == 0) sl_r = ~sl_r;
                step(c_r, s_r, sel_r, k_r, ($urandom_range(0, 3) != 0), sl_r,
                     ($urandom_range(0, 99) == 0), "R1 R6 R8 random");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule